// File: doc/BRIEF.md
# Lane power sequencer

This block moves a group of serial output lanes between the powered-down and powered-up states one lane at a time. Software issues a single control write. The write carries a trigger bit, the target state, the direction in which to walk the lanes and a gap value. The block then visits every lane in the chosen order and changes its power-down output. Between adjacent lane changes it waits a programmable number of prescaled ticks. When the last lane has moved, it raises a done flag, which software polls.

A lane-count input picks the lanes that a power-up may release. A count of one, two or four enables the lowest one, two or four lanes. Any other count is refused, and the previous enable set is kept. In normal use a power-up walks from the top lane down and a power-down walks from lane 0 up. A gap of 15 suits the slow single-ended panel mode and a gap of 1 suits the packetised link mode.

Top module: `lane_pwr_seq`

## Requirements
- R1: After reset every bit of `lane_pd` is 1 (1 = lane powered down) and `seq_done` is 0.
- R2: A write with `ctl_wr`=1 and `ctl_trigger`=1, sampled at a rising edge while no sequence runs, starts a sequence. `seq_done` is 0 after that edge, and the first lane change appears at the next rising edge.
- R3: With `ctl_dir_down`=1 the lanes are visited from NUM_LANES-1 down to 0. With `ctl_dir_down`=0 they are visited from 0 up to NUM_LANES-1. Exactly one lane changes per visit.
- R4: With gap value N on `ctl_delay`, adjacent lane visits are N*PRESCALE+1 clock cycles apart. N=0 gives visits on consecutive cycles.
- R5: With `ctl_power_up`=1 each visited lane ends with `lane_pd` 0 if it is in the enable set and 1 otherwise. With `ctl_power_up`=0 each visited lane ends with `lane_pd` 1.
- R6: The enable set is taken from `lane_count` when a write starts a sequence: 1 gives lane 0, 2 gives lanes 0 and 1, 4 gives lanes 0 to 3.
- R7: Any other `lane_count` value (0, 3, 5, 6, 7) leaves the enable set as it was. After reset the enable set is empty.
- R8: `seq_done` rises at the same edge as the last lane change and stays 1 until the next write that starts a sequence.
- R9: A triggered write that arrives while a sequence runs is ignored. The running sequence keeps its order, gap, target and enable set.
- R10: A write with `ctl_trigger`=0 changes nothing. While no sequence runs, `lane_pd` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_trigger | input | 1 | Trigger bit of the control word |
| ctl_power_up | input | 1 | Target state: 1 power up, 0 power down |
| ctl_dir_down | input | 1 | Walk order: 1 top lane first, 0 lane 0 first |
| ctl_delay | input | DLY_W | Gap between lane visits, in prescaled ticks |
| lane_count | input | $clog2(NUM_LANES)+1 | Requested number of active lanes |
| lane_pd | output | NUM_LANES | Per-lane power-down, 1 = down |
| seq_done | output | 1 | Sequence finished |

## Verification
A wrong step index or a wrong direction shows on `lane_pd` at the first visit, one cycle after the trigger: the wrong bit moves. A miscounted gap moves the second lane change off its cycle, so the error appears within one gap. A stale or wrongly refused enable set shows as a lane left up or down at the end of a power-up. A wrongly accepted busy trigger restarts the walk, which shows at the next visit. The bench compares `lane_pd` and `seq_done` on every cycle of every sequence.

// File: rtl/lps_pkg.sv
package lps_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/lps_tick.sv
module lps_tick #(
   parameter int PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);
   generate
      if (PRESCALE == 1) begin : g_direct
         logic unused_tick_in;
         assign unused_tick_in = ^{clk, rst_n, restart};
         assign tick = run;
      end else begin : g_count
         localparam int PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (restart)  cnt_q <= '0;
            else if (run)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/lps_mask.sv
module lps_mask #(
   parameter int NUM_LANES = 4,
   parameter int CNT_W     = 3
) (
   input  logic [CNT_W-1:0]     lane_count,
   output logic                 valid,
   output logic [NUM_LANES-1:0] mask
);
   logic pow2;
   assign pow2  = (lane_count != '0) && ((lane_count & (lane_count - 1'b1)) == '0);
   assign valid = pow2 && (lane_count <= CNT_W'(NUM_LANES));
   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_bit
         assign mask[i] = valid && (CNT_W'(i) < lane_count);
      end
   endgenerate
endmodule

// File: rtl/lps_order.sv
module lps_order #(
   parameter int NUM_LANES = 4,
   parameter int IDX_W     = 2
) (
   input  logic [IDX_W-1:0]     step,
   input  logic                 dir_down,
   output logic [NUM_LANES-1:0] lane_hot,
   output logic                 last
);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_LANES - 1);
   logic [IDX_W-1:0] lane_idx;
   assign lane_idx = dir_down ? (TOP - step) : step;
   assign last     = (step == TOP);
   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_hot
         assign lane_hot[i] = (lane_idx == IDX_W'(i));
      end
   endgenerate
endmodule

// File: rtl/lane_pwr_seq.sv
module lane_pwr_seq
   import lps_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int DLY_W     = 4,
   parameter int PRESCALE  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ctl_wr,
   input  logic                       ctl_trigger,
   input  logic                       ctl_power_up,
   input  logic                       ctl_dir_down,
   input  logic [DLY_W-1:0]           ctl_delay,
   input  logic [$clog2(NUM_LANES):0] lane_count,
   output logic [NUM_LANES-1:0]       lane_pd,
   output logic                       seq_done
);
   localparam int CNT_W = $clog2(NUM_LANES) + 1;
   localparam int IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

   generate
      if (NUM_LANES < 1 || (NUM_LANES & (NUM_LANES - 1)) != 0) begin : g_bad_lanes
         $error("NUM_LANES must be a power of two");
      end
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("DLY_W must be at least 1");
      end
   endgenerate

   seq_state_e           state_q;
   logic                 run_act;
   logic                 up_q;
   logic                 down_q;
   logic [DLY_W-1:0]     gap_q;
   logic [DLY_W-1:0]     wait_q;
   logic [IDX_W-1:0]     step_q;
   logic [NUM_LANES-1:0] mask_q;
   logic [NUM_LANES-1:0] pd_q;
   logic [NUM_LANES-1:0] pd_next;
   logic                 done_q;

   logic                 accept;
   logic                 fire;
   logic                 tick;
   logic                 cnt_ok;
   logic [NUM_LANES-1:0] cnt_mask;
   logic [NUM_LANES-1:0] lane_hot;
   logic                 last_step;

   assign run_act = (state_q == SEQ_RUN);
   assign accept  = ctl_wr && ctl_trigger && (state_q == SEQ_IDLE);
   assign fire    = run_act && (wait_q == '0);

   lps_mask #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_mask (
      .lane_count (lane_count),
      .valid      (cnt_ok),
      .mask       (cnt_mask)
   );

   lps_order #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_order (
      .step     (step_q),
      .dir_down (down_q),
      .lane_hot (lane_hot),
      .last     (last_step)
   );

   lps_tick #(.PRESCALE(PRESCALE)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept || fire),
      .run     (run_act),
      .tick    (tick)
   );

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_next
         assign pd_next[i] = lane_hot[i] ? (up_q ? ~mask_q[i] : 1'b1) : pd_q[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         up_q    <= 1'b0;
         down_q  <= 1'b0;
         gap_q   <= '0;
         wait_q  <= '0;
         step_q  <= '0;
         mask_q  <= '0;
         pd_q    <= '1;
         done_q  <= 1'b0;
      end else if (accept) begin
         state_q <= SEQ_RUN;
         up_q    <= ctl_power_up;
         down_q  <= ctl_dir_down;
         gap_q   <= ctl_delay;
         wait_q  <= '0;
         step_q  <= '0;
         done_q  <= 1'b0;
         if (cnt_ok) mask_q <= cnt_mask;
      end else if (fire) begin
         pd_q <= pd_next;
         if (last_step) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
         end else begin
            step_q <= step_q + 1'b1;
            wait_q <= gap_q;
         end
      end else if (run_act && tick) begin
         wait_q <= wait_q - 1'b1;
      end
   end

   assign lane_pd  = pd_q;
   assign seq_done = done_q;
endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
   parameter int NUM_LANES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ctl_wr,
   input logic                 ctl_trigger,
   input logic [NUM_LANES-1:0] lane_pd,
   input logic                 seq_done,
   input logic                 run,
   input logic                 tgt_up
);
   logic take;
   assign take = ctl_wr && ctl_trigger && !run;

   p_done_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !seq_done);

   p_single_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lane_pd ^ $past(lane_pd)) <= 1);

   p_down_no_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tgt_up) |=> ((lane_pd & $past(lane_pd)) == $past(lane_pd)));

   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !take) |=> seq_done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !run);

   p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !take) |=> $stable(lane_pd));
endmodule

bind lane_pwr_seq lps_checker #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_wr      (ctl_wr),
   .ctl_trigger (ctl_trigger),
   .lane_pd     (lane_pd),
   .seq_done    (seq_done),
   .run         (run_act),
   .tgt_up      (up_q)
);

// File: tb/tb_lane_pwr_seq.sv
module tb_lane_pwr_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 4;
   localparam int DW = 4;
   localparam int PS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic          ctl_trigger = 1'b0;
   logic          ctl_power_up = 1'b0;
   logic          ctl_dir_down = 1'b0;
   logic [DW-1:0] ctl_delay = '0;
   logic [2:0]    lane_count = '0;
   logic [NL-1:0] lane_pd;
   logic          seq_done;

   int n_chk = 0;
   int n_fail = 0;
   logic [NL-1:0] m_pd = '1;
   logic [NL-1:0] m_mask = '0;
   logic          m_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_pwr_seq #(.NUM_LANES(NL), .DLY_W(DW), .PRESCALE(PS)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_trigger(ctl_trigger),
      .ctl_power_up(ctl_power_up), .ctl_dir_down(ctl_dir_down),
      .ctl_delay(ctl_delay), .lane_count(lane_count),
      .lane_pd(lane_pd), .seq_done(seq_done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [NL-1:0] mask_for(input logic [2:0] cnt, input logic [NL-1:0] old);
      case (cnt)
         3'd1:    return 4'b0001;
         3'd2:    return 4'b0011;
         3'd4:    return 4'b1111;
         default: return old;
      endcase
   endfunction

   // Called at a falling edge; returns at a falling edge.
   task automatic do_seq(input string tag, input bit pu, input bit dn, input int dly,
                         input int cnt, input bit poke);
      int gap;
      int total;
      ctl_wr = 1'b1; ctl_trigger = 1'b1; ctl_power_up = pu; ctl_dir_down = dn;
      ctl_delay = DW'(dly); lane_count = 3'(cnt);
      @(negedge clk);
      ctl_wr = 1'b0; ctl_trigger = 1'b0;
      m_mask = mask_for(3'(cnt), m_mask);
      m_done = 1'b0;
      check({tag, " R2 done cleared"}, 32'(seq_done), 32'(m_done));
      gap = dly * PS + 1;
      total = 1 + (NL - 1) * gap;
      for (int m = 1; m <= total; m++) begin
         @(negedge clk);
         ctl_wr = 1'b0; ctl_trigger = 1'b0;
         if ((m - 1) % gap == 0) begin
            int k;
            int lane;
            k = (m - 1) / gap;
            lane = dn ? (NL - 1 - k) : k;
            m_pd[lane] = pu ? ~m_mask[lane] : 1'b1;
            if (k == NL - 1) m_done = 1'b1;
         end
         check($sformatf("%s R3 R4 R5 R6 lane_pd cycle %0d", tag, m), 32'(lane_pd), 32'(m_pd));
         check($sformatf("%s R8 seq_done cycle %0d", tag, m), 32'(seq_done), 32'(m_done));
         if (poke && m == 2) begin
            // R9: busy trigger with different settings must be ignored
            ctl_wr = 1'b1; ctl_trigger = 1'b1; ctl_power_up = ~pu; ctl_dir_down = ~dn;
            ctl_delay = '0; lane_count = 3'd1;
         end
      end
      repeat (3) @(negedge clk);
      check({tag, " R10 idle lane_pd"}, 32'(lane_pd), 32'(m_pd));
      check({tag, " R8 done held"}, 32'(seq_done), 32'(m_done));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1207));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset lane_pd", 32'(lane_pd), 32'hF);
      check("R1 reset seq_done", 32'(seq_done), 32'h0);

      // R7: refused count with empty enable set keeps all lanes down
      do_seq("R7 empty set", 1'b1, 1'b1, 0, 3, 1'b0);
      // R6: packetised link gap, four lanes
      do_seq("R6 four lanes up", 1'b1, 1'b1, 1, 4, 1'b0);
      do_seq("R5 all down", 1'b0, 1'b0, 1, 4, 1'b0);
      // R4: panel mode gap 15, two lanes
      do_seq("R4 gap15 two lanes", 1'b1, 1'b1, 15, 2, 1'b0);
      do_seq("R3 down walk up", 1'b0, 1'b0, 0, 1, 1'b0);
      // R7: count 0 keeps the one-lane set
      do_seq("R7 keep set", 1'b1, 1'b1, 2, 0, 1'b0);
      do_seq("R7 down", 1'b0, 1'b0, 2, 6, 1'b0);
      // R9: busy trigger ignored
      do_seq("R9 busy ignore", 1'b1, 1'b1, 3, 4, 1'b1);

      // R10: write without trigger bit
      ctl_wr = 1'b1; ctl_trigger = 1'b0; ctl_power_up = 1'b0; ctl_dir_down = 1'b0;
      lane_count = 3'd1; ctl_delay = '0;
      @(negedge clk);
      ctl_wr = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 no-trigger lane_pd", 32'(lane_pd), 32'(m_pd));
      check("R10 no-trigger seq_done", 32'(seq_done), 32'(m_done));

      for (int r = 0; r < 30; r++) begin
         do_seq($sformatf("random %0d", r), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 7)),
                1'($urandom_range(0, 1)));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule